// File: doc/BRIEF.md
# Global Comparator Timer

A free-running 64-bit up-counter with a 64-bit compare value and a sticky event flag that raises an interrupt line. Software reaches it through a small 32-bit register bus with a word index. The counter advances on a tick from a simple clock divider, and only while the timer is running. A delay loop can poll the counter whether or not the comparator is in use.

When the counter reaches or passes the compare value and the comparator is on, the event flag sets and stays set until software clears it. With automatic rescheduling on, each match adds a programmable step to the compare value, so periodic events follow without any software reload. With rescheduling off, the comparator fires once per arming. The counter words are not latched together. A reader therefore reads the high word, then the low word, then the high word again.

Top module: `gcmp_timer`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low.
- R2: Control bit 0 runs the timer. Control bits 15:8 hold a divider value P. While running, the counter rises by one every P+1 clock cycles, and while stopped it holds.
- R3: The counter's low word is at index 0 and its high word at index 1. Each read returns the live word, and a carry out of the low word appears in the high word.
- R4: Writes to the counter words load them only while the timer is stopped. While it runs, those writes leave the count untouched.
- R5: The event flag is bit 0 of the status register at index 3. It sets when control bit 1 (comparator on) is set and the counter is at or above the compare value (low word index 4, high word index 5). It never sets while bit 1 is clear.
- R6: Writing status with bit 0 = 1 clears the flag. Writing it with bit 0 = 0 leaves the flag as it is.
- R7: With control bit 3 clear, a match sets the flag once. The comparator re-arms only on a write to either compare word or on a 0-to-1 change of control bit 1.
- R8: With control bit 3 set, each match adds the step register (index 6) to the compare value, and the comparator stays armed.
- R9: `irq_o` goes high one cycle after the flag is set while control bit 2 is high. It stays low whenever bit 2 is low.
- R10: A read returns its data on `bus_rdata` one cycle after the request. The control register reads back bits 3:0 and 15:8 as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_o | output | 1 | Interrupt request, registered |

## Verification
The bench uses the default parameters: 32-bit words and an 8-bit divider. Divider value 3 checks the tick spacing, and divider value 0 gives exact cycle counts for the compare runs. Preloading the counter just below a low-word carry brings the carry into the high word within a few cycles. A step of 10 with a 35-cycle run covers three automatic reschedules, and a later counter write exercises the catch-up match.

// File: rtl/gcmp_pkg.sv
package gcmp_pkg;
  localparam int IDX_W = 3;

  typedef enum logic [IDX_W-1:0] {
    REG_CNT_LO = 3'd0,
    REG_CNT_HI = 3'd1,
    REG_CTRL   = 3'd2,
    REG_STAT   = 3'd3,
    REG_CMP_LO = 3'd4,
    REG_CMP_HI = 3'd5,
    REG_STEP   = 3'd6
  } reg_idx_e;

  localparam int CTL_RUN     = 0;
  localparam int CTL_CMP     = 1;
  localparam int CTL_IRQ     = 2;
  localparam int CTL_AUTO    = 3;
  localparam int CTL_PRE_LSB = 8;
endpackage

// File: rtl/gcmp_prescale.sv
module gcmp_prescale #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);
  logic [PRE_W-1:0] phase_q;

  assign tick = run && (phase_q == div);

  always_ff @(posedge clk) begin
    if (rst || !run) phase_q <= '0;
    else if (phase_q == div) phase_q <= '0;
    else phase_q <= phase_q + PRE_W'(1);
  end
endmodule

// File: rtl/gcmp_counter.sv
module gcmp_counter #(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run,
  input  logic                tick,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [DATA_W-1:0]   wdata,
  output logic [2*DATA_W-1:0] cnt_o
);
  localparam int CNT_W = 2 * DATA_W;
  logic [CNT_W-1:0] cnt_q;

  assign cnt_o = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!run && (wr_lo || wr_hi)) begin
      if (wr_lo) cnt_q[DATA_W-1:0]     <= wdata;
      if (wr_hi) cnt_q[CNT_W-1:DATA_W] <= wdata;
    end else if (tick) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/gcmp_compare.sv
module gcmp_compare #(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2*DATA_W-1:0] cnt,
  input  logic                cmp_en,
  input  logic                cmp_rise,
  input  logic                auto_en,
  input  logic [DATA_W-1:0]   step,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                flag_clr,
  output logic [2*DATA_W-1:0] cmp_o,
  output logic                flag_o
);
  localparam int CNT_W = 2 * DATA_W;
  logic [CNT_W-1:0] cmp_q;
  logic             armed_q;
  logic             flag_q;
  logic             match;

  assign match  = cmp_en && armed_q && (cnt >= cmp_q);
  assign cmp_o  = cmp_q;
  assign flag_o = flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q   <= '0;
      armed_q <= 1'b0;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) cmp_q[DATA_W-1:0]     <= wdata;
      if (wr_hi) cmp_q[CNT_W-1:DATA_W] <= wdata;
      armed_q <= 1'b1;
    end else if (match) begin
      if (auto_en) cmp_q <= cmp_q + CNT_W'(step);
      else armed_q <= 1'b0;
    end else if (cmp_rise) begin
      armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else if (match) flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end
endmodule

// File: rtl/gcmp_timer.sv
module gcmp_timer
  import gcmp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [IDX_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  localparam int CNT_W = 2 * DATA_W;

  logic              ctl_run, ctl_cmp, ctl_irq, ctl_auto;
  logic [PRE_W-1:0]  pre_q;
  logic [DATA_W-1:0] step_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_mux;
  logic              irq_q;
  logic              tick;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cmp;
  logic              flag;

  logic     wr_en, rd_en;
  reg_idx_e idx;
  logic     cnt_wr_lo, cnt_wr_hi, cnt_wr;
  logic     cmp_wr_lo, cmp_wr_hi, cmp_wr;
  logic     ctl_wr, step_wr, flag_clr, cmp_rise;

  assign wr_en     = bus_sel && bus_wr;
  assign rd_en     = bus_sel && !bus_wr;
  assign idx       = reg_idx_e'(bus_addr);
  assign cnt_wr_lo = wr_en && (idx == REG_CNT_LO);
  assign cnt_wr_hi = wr_en && (idx == REG_CNT_HI);
  assign cnt_wr    = cnt_wr_lo || cnt_wr_hi;
  assign cmp_wr_lo = wr_en && (idx == REG_CMP_LO);
  assign cmp_wr_hi = wr_en && (idx == REG_CMP_HI);
  assign cmp_wr    = cmp_wr_lo || cmp_wr_hi;
  assign ctl_wr    = wr_en && (idx == REG_CTRL);
  assign step_wr   = wr_en && (idx == REG_STEP);
  assign flag_clr  = wr_en && (idx == REG_STAT) && bus_wdata[0];
  assign cmp_rise  = ctl_wr && bus_wdata[CTL_CMP] && !ctl_cmp;

  gcmp_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .run(ctl_run), .div(pre_q), .tick(tick)
  );

  gcmp_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .run(ctl_run), .tick(tick),
    .wr_lo(cnt_wr_lo), .wr_hi(cnt_wr_hi), .wdata(bus_wdata), .cnt_o(cnt)
  );

  gcmp_compare #(.DATA_W(DATA_W)) u_cmp (
    .clk(clk), .rst(rst), .cnt(cnt), .cmp_en(ctl_cmp), .cmp_rise(cmp_rise),
    .auto_en(ctl_auto), .step(step_q), .wr_lo(cmp_wr_lo), .wr_hi(cmp_wr_hi),
    .wdata(bus_wdata), .flag_clr(flag_clr), .cmp_o(cmp), .flag_o(flag)
  );

  always_comb begin
    rd_mux = '0;
    case (idx)
      REG_CNT_LO: rd_mux = cnt[DATA_W-1:0];
      REG_CNT_HI: rd_mux = cnt[CNT_W-1:DATA_W];
      REG_CTRL: begin
        rd_mux[CTL_RUN]                = ctl_run;
        rd_mux[CTL_CMP]                = ctl_cmp;
        rd_mux[CTL_IRQ]                = ctl_irq;
        rd_mux[CTL_AUTO]               = ctl_auto;
        rd_mux[CTL_PRE_LSB +: PRE_W]   = pre_q;
      end
      REG_STAT:   rd_mux[0] = flag;
      REG_CMP_LO: rd_mux = cmp[DATA_W-1:0];
      REG_CMP_HI: rd_mux = cmp[CNT_W-1:DATA_W];
      REG_STEP:   rd_mux = step_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_run  <= 1'b0;
      ctl_cmp  <= 1'b0;
      ctl_irq  <= 1'b0;
      ctl_auto <= 1'b0;
      pre_q    <= '0;
      step_q   <= '0;
      rdata_q  <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (ctl_wr) begin
        ctl_run  <= bus_wdata[CTL_RUN];
        ctl_cmp  <= bus_wdata[CTL_CMP];
        ctl_irq  <= bus_wdata[CTL_IRQ];
        ctl_auto <= bus_wdata[CTL_AUTO];
        pre_q    <= bus_wdata[CTL_PRE_LSB +: PRE_W];
      end
      if (step_wr) step_q <= bus_wdata;
      if (rd_en) rdata_q <= rd_mux;
      irq_q <= flag && ctl_irq;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/gcmp_timer_chk.sv
module gcmp_timer_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             cmp_en,
  input logic             auto_en,
  input logic             irq_en,
  input logic             flag,
  input logic             irq,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp,
  input logic             cnt_wr,
  input logic             cmp_wr,
  input logic             flag_clr
);
  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (rst)
    run |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1)));

  assert_cnt_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_wr) |=> $stable(cnt));

  assert_no_match_R5: assert property (@(posedge clk) disable iff (rst)
    (!cmp_en && !flag) |=> !flag);

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (flag && !flag_clr) |=> flag);

  assert_cmp_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!auto_en && !cmp_wr) |=> $stable(cmp));

  assert_irq_mask_R9: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq);
endmodule

bind gcmp_timer gcmp_timer_chk #(.CNT_W(2 * DATA_W)) chk_i (
  .clk(clk), .rst(rst), .run(ctl_run), .cmp_en(ctl_cmp), .auto_en(ctl_auto),
  .irq_en(ctl_irq), .flag(flag), .irq(irq_o), .cnt(cnt), .cmp(cmp),
  .cnt_wr(cnt_wr), .cmp_wr(cmp_wr), .flag_clr(flag_clr)
);

// File: tb/gcmp_timer_tb_top.sv
`timescale 1ns/1ps
module gcmp_timer_tb_top;
  import gcmp_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int  vectors = 0;
  int  miscompares = 0;
  bit  done = 1'b0;
  logic rd_pend = 1'b0;

  typedef struct {
    logic [31:0] d;
    string       tag;
  } exp_t;
  exp_t expq[$];

  always #2 clk = ~clk;

  gcmp_timer dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o)
  );

  // monitor: a read issued before an edge returns its data after that edge
  always @(posedge clk) rd_pend <= bus_sel && !bus_wr;

  always @(negedge clk) begin
    if (rd_pend && expq.size() > 0) begin
      exp_t e;
      e = expq.pop_front();
      vectors++;
      if (bus_rdata !== e.d) begin
        miscompares++;
        $display("FAIL %s: actual %h expected %h", e.tag, bus_rdata, e.d);
      end
    end
  end

  task automatic wr(input reg_idx_e a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input reg_idx_e a, input logic [31:0] e, input string tag);
    expq.push_back('{d: e, tag: tag});
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    vectors++;
    if (irq_o !== e) begin
      miscompares++;
      $display("FAIL %s: actual %b expected %b", tag, irq_o, e);
    end
  endtask

  // timer runs for n edges, then stops; counter gains n/(pre+1)
  task automatic run_for(input logic [7:0] pre, input logic [3:0] bits, input int n);
    wr(REG_CTRL, {16'h0, pre, 4'h0, bits | 4'h1});
    repeat (n - 1) @(negedge clk);
    wr(REG_CTRL, {16'h0, pre, 4'h0, bits & 4'he});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog (all requirements): actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(REG_CNT_LO, 32'h0, "R1 cnt lo");
    rd(REG_CNT_HI, 32'h0, "R1 cnt hi");
    rd(REG_CTRL,   32'h0, "R1 ctrl");
    rd(REG_STAT,   32'h0, "R1 stat");
    rd(REG_CMP_LO, 32'h0, "R1 cmp lo");
    rd(REG_CMP_HI, 32'h0, "R1 cmp hi");
    rd(REG_STEP,   32'h0, "R1 step");
    chk_irq(1'b0, "R1 irq");

    // R4 load while stopped, R3 carry into high word
    wr(REG_CNT_LO, 32'hFFFF_FFFE);
    wr(REG_CNT_HI, 32'h0000_0007);
    rd(REG_CNT_LO, 32'hFFFF_FFFE, "R4 load lo");
    rd(REG_CNT_HI, 32'h0000_0007, "R4 load hi");
    run_for(8'd0, 4'h0, 3);
    rd(REG_CNT_HI, 32'h0000_0008, "R3 carry hi");
    rd(REG_CNT_LO, 32'h0000_0001, "R3 carry lo");

    // R2 divider: 22 cycles at P=3 -> 5 ticks
    wr(REG_CNT_LO, 32'h0);
    wr(REG_CNT_HI, 32'h0);
    run_for(8'd3, 4'h0, 22);
    rd(REG_CNT_LO, 32'd5, "R2 divided count");
    rd(REG_CTRL, 32'h0000_0300, "R10 ctrl readback");
    repeat (4) @(negedge clk);
    rd(REG_CNT_LO, 32'd5, "R2 hold when stopped");

    // R4 writes ignored while running: 10 edges enabled
    wr(REG_CNT_LO, 32'h0);
    wr(REG_CTRL, 32'h1);
    repeat (4) @(negedge clk);
    wr(REG_CNT_LO, 32'h0000_1234);
    wr(REG_CNT_HI, 32'h0000_0055);
    repeat (3) @(negedge clk);
    wr(REG_CTRL, 32'h0);
    rd(REG_CNT_LO, 32'd10, "R4 ignored lo");
    rd(REG_CNT_HI, 32'd0, "R4 ignored hi");

    // R5 comparator off: counter 10 >= compare 5 but no flag
    wr(REG_CMP_LO, 32'd5);
    wr(REG_CMP_HI, 32'd0);
    wr(REG_CTRL, 32'h4);
    repeat (3) @(negedge clk);
    rd(REG_STAT, 32'h0, "R5 no match while off");
    chk_irq(1'b0, "R5 irq while off");

    // R5 / R9 comparator on
    wr(REG_CTRL, 32'h6);
    repeat (2) @(negedge clk);
    rd(REG_STAT, 32'h1, "R5 match sets flag");
    chk_irq(1'b1, "R9 irq raised");

    // R6 clear semantics
    wr(REG_STAT, 32'h0);
    rd(REG_STAT, 32'h1, "R6 write 0 keeps flag");
    wr(REG_STAT, 32'h1);
    rd(REG_STAT, 32'h0, "R6 write 1 clears");
    // R7 one shot
    repeat (3) @(negedge clk);
    rd(REG_STAT, 32'h0, "R7 no second match");
    chk_irq(1'b0, "R7 irq stays low");
    rd(REG_CMP_LO, 32'd5, "R7 compare unchanged");

    // R7 rearm by compare write
    wr(REG_CMP_HI, 32'd0);
    @(negedge clk);
    rd(REG_STAT, 32'h1, "R7 rearm on compare write");
    wr(REG_STAT, 32'h1);

    // R7 rearm by comparator re-enable
    wr(REG_CTRL, 32'h4);
    wr(REG_CTRL, 32'h6);
    @(negedge clk);
    rd(REG_STAT, 32'h1, "R7 rearm on enable rise");
    wr(REG_STAT, 32'h1);

    // R9 mask
    wr(REG_CTRL, 32'h2);
    wr(REG_CMP_LO, 32'd5);
    repeat (2) @(negedge clk);
    chk_irq(1'b0, "R9 masked irq");
    rd(REG_STAT, 32'h1, "R9 flag set under mask");
    wr(REG_STAT, 32'h1);

    // R8 automatic reschedule: 35 cycles, compare 10, step 10 -> 40
    wr(REG_CTRL, 32'h0);
    wr(REG_CNT_LO, 32'd0);
    wr(REG_CMP_LO, 32'd10);
    wr(REG_CMP_HI, 32'd0);
    wr(REG_STEP, 32'd10);
    rd(REG_STEP, 32'd10, "R10 step readback");
    run_for(8'd0, 4'hA, 35);
    rd(REG_CNT_LO, 32'd35, "R8 count after run");
    rd(REG_CMP_LO, 32'd40, "R8 compare rescheduled");
    rd(REG_STAT, 32'h1, "R8 flag set");
    rd(REG_CTRL, 32'h0000_000A, "R10 ctrl bits");

    // R8 catch-up match while stopped: counter to 40 -> compare 50
    wr(REG_STAT, 32'h1);
    wr(REG_CNT_LO, 32'd40);
    repeat (2) @(negedge clk);
    rd(REG_CMP_LO, 32'd50, "R8 stays armed");
    rd(REG_STAT, 32'h1, "R8 flag again");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule